// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block deserializes stereo audio arriving over a three-wire link: a bit clock, a word clock that alternates between the left and right channel, and a single data line. Everything runs on the rising edge of the incoming bit clock. No other clock is used. Each completed half-frame is turned into a 24-bit parallel sample on the channel output it belongs to, with a one-cycle strobe. A pair-valid pulse marks the moment a full left/right pair has been delivered.

A two-bit format input selects one of three framings at run time: I2S, left-justified or right-justified. Frames of 32, 48 or 64 bit clocks are handled, so each half-frame is 16, 24 or 32 bits long. The block measures the bit clocks between word-clock rising edges and raises a framing-error flag when that spacing is not a legal frame length.

A small state machine tracks channel pairing and has three states:
- `ST_HUNT`: after reset, waiting for the first channel boundary.
- `ST_EMPTY`: synchronized, with no left sample pending.
- `ST_HAVE_LEFT`: a left sample has been delivered and is waiting for its right partner.

The transitions are:
- `ST_HUNT` → `ST_EMPTY` on any boundary. No sample is delivered on this transition.
- `ST_EMPTY` → `ST_HAVE_LEFT` when a left half closes.
- `ST_EMPTY` stays in `ST_EMPTY` when a right half closes without a partner. The right sample is still delivered.
- `ST_HAVE_LEFT` → `ST_EMPTY` when a right half closes. The right sample is delivered together with the pair pulse.
- `ST_HAVE_LEFT` stays in `ST_HAVE_LEFT` if another left half closes. The newer left sample is delivered.

Top module: `serial_audio_rx`

## Requirements
- R1: The format code selects the framing: `fmt` 2'b00 is I2S, 2'b01 is left-justified, 2'b10 is right-justified, and 2'b11 behaves exactly like 2'b00.
- R2: In I2S framing, word clock low is the left channel. The MSB of a half is the bit sampled one rising edge after the edge at which the new word-clock level is first seen.
- R3: In left-justified framing, word clock high is the left channel. The MSB is the bit sampled on the same rising edge at which the new word-clock level is first seen.
- R4: In right-justified framing, word clock high is the left channel. The sample is the last 24 bits of the half, with the LSB as the final bit before the word-clock change. Any earlier bits are ignored.
- R5: A half shorter than 24 bits yields an MSB-aligned sample whose unused low bits are zero. In I2S and left-justified framing, bits after the 24th of a half have no effect on the sample.
- R6: A finished half appears on `left_out` or `right_out`, with the matching strobe high for one cycle, right after the edge at which the next boundary is seen. That edge is the first edge of the following half in left-justified and right-justified framing, and one edge later in I2S framing. The sample outputs hold their value between strobes.
- R7: `pair_valid` is high exactly in the cycle of a `right_stb` that follows a left sample not yet paired.
- R8: The first channel boundary after reset only synchronizes the receiver and produces no strobe.
- R9: At every word-clock rising edge after the first, `frame_err` becomes 1 if the number of rising bit-clock edges since the previous word-clock rise is not 32, 48 or 64, and 0 otherwise. It holds between rises.
- R10: While reset is low, all outputs are zero.
- R11: `left_stb` and `right_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock; all logic uses its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk | input | 1 | Word clock marking channel halves |
| sdata | input | 1 | Serial audio data, MSB first |
| fmt | input | 2 | Framing select (00 I2S, 01 left-justified, 10 right-justified, 11 as 00) |
| left_out | output | 24 | Last delivered left sample |
| right_out | output | 24 | Last delivered right sample |
| left_stb | output | 1 | One-cycle pulse when `left_out` is updated |
| right_stb | output | 1 | One-cycle pulse when `right_out` is updated |
| pair_valid | output | 1 | One-cycle pulse when a right sample completes a pair |
| frame_err | output | 1 | Result of the last word-clock rise-to-rise length check |

## Verification
Every result is registered once, so the earliest a sample and its strobe can appear is just after the bit-clock edge at which the next boundary is seen. In I2S framing that edge is one bit later than the raw word-clock change. The framing flag updates just after the edge that samples a word-clock rise. The bench drives inputs and samples outputs on the falling bit-clock edge. It logs every strobe with its data and pair flag, and compares the log against the values expected from the frames it sent. The last frame of each burst is followed by an extra frame whose boundary flushes the final right sample out.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'b00,
        FMT_LJ   = 2'b01,
        FMT_RJ   = 2'b10,
        FMT_RSVD = 2'b11
    } srx_fmt_e;

    typedef enum logic [1:0] {
        ST_HUNT      = 2'b00,
        ST_EMPTY     = 2'b01,
        ST_HAVE_LEFT = 2'b10
    } srx_state_e;

endpackage

// File: rtl/srx_edge_track.sv
module srx_edge_track
    import srx_pkg::*;
(
    input  logic       bclk,
    input  logic       rst_n,
    input  logic       lrclk,
    input  logic [1:0] fmt,
    output logic       boundary,
    output logic       closed_left,
    output logic       lr_rise
);

    logic lr_prev;
    logic w_prev;
    logic w_now;
    logic delayed;

    // I2S and the reserved code use the delayed word clock, so that the
    // MSB lands one bit after the raw transition.
    assign delayed     = (fmt == FMT_I2S) || (fmt == FMT_RSVD);
    assign w_now       = delayed ? lr_prev : lrclk;
    assign boundary    = (w_now != w_prev);
    assign closed_left = delayed ? ~w_prev : w_prev;
    assign lr_rise     = lrclk & ~lr_prev;

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            lr_prev <= 1'b0;
            w_prev  <= 1'b0;
        end else begin
            lr_prev <= lrclk;
            w_prev  <= w_now;
        end
    end

endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 7
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                sdata,
    input  logic                boundary,
    input  logic                rj_mode,
    output logic [SAMPLE_W-1:0] word
);

    localparam int IDX_W = $clog2(SAMPLE_W);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_W_S = CNT_W'(SAMPLE_W);

    logic [SAMPLE_W-1:0] fill_q;
    logic [SAMPLE_W-1:0] fill_d;
    logic [SAMPLE_W-1:0] shreg_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    gap;
    logic [IDX_W-1:0]    idx;

    // MSB-aligned capture: bit n of a half lands at position W-1-n.
    always_comb begin
        fill_d = fill_q;
        idx    = IDX_W'(SAMPLE_W - 1) - IDX_W'(cnt_q);
        if (cnt_q < CNT_W_S) begin
            fill_d[idx] = sdata;
        end
    end

    // Right-justified: last W bits, left-aligned when fewer were seen.
    assign gap  = CNT_W_S - cnt_q;
    assign word = !rj_mode           ? fill_q :
                  (cnt_q >= CNT_W_S) ? shreg_q :
                                       (shreg_q << gap);

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q  <= '0;
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (boundary) begin
            fill_q  <= {sdata, {(SAMPLE_W-1){1'b0}}};
            shreg_q <= {{(SAMPLE_W-1){1'b0}}, sdata};
            cnt_q   <= CNT_W'(1);
        end else begin
            fill_q  <= fill_d;
            shreg_q <= {shreg_q[SAMPLE_W-2:0], sdata};
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/srx_frame_mon.sv
module srx_frame_mon #(
    parameter int CNT_W   = 7,
    parameter int LEN_A   = 32,
    parameter int LEN_B   = 48,
    parameter int LEN_C   = 64
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic lr_rise,
    output logic frame_err
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] fcnt_q;
    logic             armed_q;
    logic             legal;

    assign legal = (fcnt_q == CNT_W'(LEN_A)) ||
                   (fcnt_q == CNT_W'(LEN_B)) ||
                   (fcnt_q == CNT_W'(LEN_C));

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            fcnt_q    <= '0;
            armed_q   <= 1'b0;
            frame_err <= 1'b0;
        end else if (lr_rise) begin
            if (armed_q) begin
                frame_err <= ~legal;
            end
            armed_q <= 1'b1;
            fcnt_q  <= CNT_W'(1);
        end else if (fcnt_q != CNT_MAX) begin
            fcnt_q <= fcnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import srx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 7
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                lrclk,
    input  logic                sdata,
    input  logic [1:0]          fmt,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                left_stb,
    output logic                right_stb,
    output logic                pair_valid,
    output logic                frame_err
);

    srx_state_e          state_q;
    srx_state_e          state_d;
    logic                boundary;
    logic                closed_left;
    logic                lr_rise;
    logic [SAMPLE_W-1:0] word;

    srx_edge_track i_edge (
        .bclk        (bclk),
        .rst_n       (rst_n),
        .lrclk       (lrclk),
        .fmt         (fmt),
        .boundary    (boundary),
        .closed_left (closed_left),
        .lr_rise     (lr_rise)
    );

    srx_shifter #(
        .SAMPLE_W (SAMPLE_W),
        .CNT_W    (CNT_W)
    ) i_shift (
        .bclk     (bclk),
        .rst_n    (rst_n),
        .sdata    (sdata),
        .boundary (boundary),
        .rj_mode  (fmt == FMT_RJ),
        .word     (word)
    );

    srx_frame_mon #(
        .CNT_W (CNT_W)
    ) i_fmon (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .lr_rise   (lr_rise),
        .frame_err (frame_err)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (boundary) state_d = ST_EMPTY;
            end
            ST_EMPTY: begin
                if (boundary && closed_left) state_d = ST_HAVE_LEFT;
            end
            ST_HAVE_LEFT: begin
                if (boundary && !closed_left) state_d = ST_EMPTY;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            left_out   <= '0;
            right_out  <= '0;
            left_stb   <= 1'b0;
            right_stb  <= 1'b0;
            pair_valid <= 1'b0;
        end else begin
            left_stb   <= 1'b0;
            right_stb  <= 1'b0;
            pair_valid <= 1'b0;
            if (boundary && (state_q != ST_HUNT)) begin
                if (closed_left) begin
                    left_out <= word;
                    left_stb <= 1'b1;
                end else begin
                    right_out  <= word;
                    right_stb  <= 1'b1;
                    pair_valid <= (state_q == ST_HAVE_LEFT);
                end
            end
        end
    end

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int SAMPLE_W = 24
) (
    input logic                bclk,
    input logic                rst_n,
    input logic                lrclk,
    input logic [SAMPLE_W-1:0] left_out,
    input logic [SAMPLE_W-1:0] right_out,
    input logic                left_stb,
    input logic                right_stb,
    input logic                pair_valid,
    input logic                frame_err
);

    // R7: a pair pulse only rides on a right strobe
    a_r7_pair_on_right: assert property (@(posedge bclk) disable iff (!rst_n)
        pair_valid |-> right_stb);

    // R11: the two channel strobes never coincide
    a_r11_stb_exclusive: assert property (@(posedge bclk) disable iff (!rst_n)
        !(left_stb && right_stb));

    // R6: strobes last a single cycle
    a_r6_left_stb_single: assert property (@(posedge bclk) disable iff (!rst_n)
        left_stb |=> !left_stb);

    a_r6_right_stb_single: assert property (@(posedge bclk) disable iff (!rst_n)
        right_stb |=> !right_stb);

    // R6: sample outputs hold when no strobe accompanies them
    a_r6_left_hold: assert property (@(posedge bclk) disable iff (!rst_n)
        !left_stb |-> $stable(left_out));

    a_r6_right_hold: assert property (@(posedge bclk) disable iff (!rst_n)
        !right_stb |-> $stable(right_out));

    // R9: the error flag moves only after a sampled word-clock rise
    a_r9_err_on_rise: assert property (@(posedge bclk) disable iff (!rst_n)
        !$stable(frame_err) |-> ($past(lrclk) && !$past(lrclk, 2)));

endmodule

bind serial_audio_rx srx_checker #(.SAMPLE_W(SAMPLE_W)) i_srx_checker (
    .bclk       (bclk),
    .rst_n      (rst_n),
    .lrclk      (lrclk),
    .left_out   (left_out),
    .right_out  (right_out),
    .left_stb   (left_stb),
    .right_stb  (right_stb),
    .pair_valid (pair_valid),
    .frame_err  (frame_err)
);

// File: tb/test_serial_audio_rx.sv
`timescale 1ns/1ps
module test_serial_audio_rx;

    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lrclk = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic [23:0] left_out;
    logic [23:0] right_out;
    logic        left_stb;
    logic        right_stb;
    logic        pair_valid;
    logic        frame_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [23:0] lq [64];
    logic [23:0] rq [64];
    bit          rp [64];
    int ln = 0;
    int rn = 0;
    int both = 0;

    always #2 bclk = ~bclk;

    serial_audio_rx i_serial_audio_rx (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .lrclk      (lrclk),
        .sdata      (sdata),
        .fmt        (fmt),
        .left_out   (left_out),
        .right_out  (right_out),
        .left_stb   (left_stb),
        .right_stb  (right_stb),
        .pair_valid (pair_valid),
        .frame_err  (frame_err)
    );

    // strobe log, sampled away from the active edge
    always @(negedge bclk) begin
        if (left_stb && right_stb) both++;
        if (left_stb && ln < 64) begin lq[ln] = left_out; ln++; end
        if (right_stb && rn < 64) begin rq[rn] = right_out; rp[rn] = pair_valid; rn++; end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] mkword(input int seed, input int idx);
        logic [31:0] v;
        v = (32'(seed) * 32'd7919 + 32'(idx) * 32'd40503 + 32'd12345) * 32'd2654435761;
        return v[31:8];
    endfunction

    function automatic logic [23:0] expect_word(input bit rj, input int h, input logic [23:0] w);
        if (h >= 24) return w;
        if (rj) return w << (24 - h);
        return w & ~((24'h1 << (24 - h)) - 24'h1);
    endfunction

    function automatic bit bitval(input bit rj, input int h, input logic [23:0] w, input int i);
        int pos;
        if (rj) begin
            pos = h - 1 - i;
            return (pos < 24) ? w[pos] : 1'b1;
        end
        return (i < 24) ? w[23 - i] : 1'b1;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        lrclk = 1'b0;
        sdata = 1'b0;
        repeat (4) @(negedge bclk);
        rst_n = 1'b1;
        @(negedge bclk);
    endtask

    // dummy frame, k data frames, one flush frame; all halves of h bits
    task automatic run_burst(input logic [1:0] f, input int h, input int k, input int seed,
                             input bit exp_err, input string tag);
        bit i2s, rj, prev, b, level;
        logic [23:0] w;
        int nh;
        i2s = (f == 2'b00) || (f == 2'b11);
        rj  = (f == 2'b10);
        fmt = f;
        ln = 0; rn = 0;
        nh = 2 * (k + 2);
        prev = 1'b1;
        for (int hf = 0; hf < nh; hf++) begin
            w = mkword(seed, hf);
            level = ((hf % 2) == 0) ^ i2s;
            for (int i = 0; i < h; i++) begin
                @(negedge bclk);
                b = bitval(rj, h, w, i);
                lrclk = level;
                sdata = i2s ? prev : b;
                prev = b;
            end
        end
        @(negedge bclk);
        sdata = prev;
        repeat (4) @(negedge bclk);
        // R6: one left per data frame plus the flush frame, one right per data frame
        check(ln >= k + 1, {tag, " R6 left count"}, 32'(ln), 32'(k + 1));
        check(rn >= k, {tag, " R6 right count"}, 32'(rn), 32'(k));
        for (int fr = 1; fr <= k; fr++) begin
            logic [23:0] el, er;
            int li, ri;
            el = expect_word(rj, h, mkword(seed, 2 * fr));
            er = expect_word(rj, h, mkword(seed, 2 * fr + 1));
            li = ln - 2 - (k - fr);
            ri = rn - 1 - (k - fr);
            if (li >= 0 && ri >= 0) begin
                check(lq[li] == el, {tag, " left sample"}, 32'(lq[li]), 32'(el));
                check(rq[ri] == er, {tag, " right sample"}, 32'(rq[ri]), 32'(er));
                check(rp[ri] == 1'b1, {tag, " R7 pair_valid with right"}, 32'(rp[ri]), 32'd1);
            end
        end
        check(frame_err == exp_err, {tag, " R9 frame_err"}, 32'(frame_err), 32'(exp_err));
        check(both == 0, {tag, " R11 strobes overlap"}, 32'(both), 32'd0);
    endtask

    task automatic t_reset_state();
        do_reset();
        check(left_out == 24'h0 && right_out == 24'h0, "R10 sample outputs at reset",
              32'(left_out | right_out), 32'd0);
        check(!left_stb && !right_stb && !pair_valid, "R10 strobes at reset",
              32'({left_stb, right_stb, pair_valid}), 32'd0);
        check(frame_err == 1'b0, "R10 frame_err at reset", 32'(frame_err), 32'd0);
    endtask

    task automatic t_hunt_only();
        do_reset();
        ln = 0; rn = 0;
        fmt = 2'b01;
        for (int i = 0; i < 20; i++) begin
            @(negedge bclk);
            lrclk = 1'b1;
            sdata = i[0];
        end
        repeat (4) @(negedge bclk);
        check(ln == 0 && rn == 0, "R8 first boundary gives no strobe", 32'(ln + rn), 32'd0);
    endtask

    task automatic t_formats();
        do_reset(); run_burst(2'b01, 32, 3, 1, 1'b0, "R3 LJ h32 R5");
        do_reset(); run_burst(2'b01, 24, 3, 2, 1'b0, "R3 LJ h24");
        do_reset(); run_burst(2'b01, 16, 3, 3, 1'b0, "R5 LJ h16");
        do_reset(); run_burst(2'b00, 32, 3, 4, 1'b0, "R2 I2S h32 R5");
        do_reset(); run_burst(2'b00, 24, 3, 5, 1'b0, "R2 I2S h24");
        do_reset(); run_burst(2'b00, 16, 3, 6, 1'b0, "R5 I2S h16");
        do_reset(); run_burst(2'b10, 32, 3, 7, 1'b0, "R4 RJ h32");
        do_reset(); run_burst(2'b10, 24, 3, 8, 1'b0, "R4 RJ h24");
        do_reset(); run_burst(2'b10, 16, 3, 9, 1'b0, "R5 RJ h16");
        do_reset(); run_burst(2'b11, 24, 3, 10, 1'b0, "R1 reserved as I2S");
    endtask

    task automatic t_frame_error();
        do_reset();
        run_burst(2'b01, 20, 3, 11, 1'b1, "R9 40-bit frames");
        run_burst(2'b01, 24, 3, 12, 1'b0, "R9 recovery");
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_hunt_only();
        t_formats();
        t_frame_error();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule